// File: doc/BRIEF.md
# Read Latency Calibration and Valid Alignment

This block calibrates the read return path of a memory built from several narrower devices placed side by side. Once the capture-clock centering step reports completion, it runs two steps. The first is edge alignment. It writes a known pattern, reads continuously and checks every byte group. A group whose words arrive rotated by half a word is on the falling half of the divided capture clock. That group receives a single edge-advance pulse, which moves its divided clock by one fast-clock cycle, and it is then checked again.

The second step is latency equalisation. The block writes a second pattern, issues exactly one read and counts clock edges until each device returns that pattern. From these counts it chooses one fixed latency. This is the configured value when that value is enabled and large enough. Otherwise it is the largest measured count. It then delays each device's data by the difference, so every device presents its data in the same cycle, and it delays the per-command read strobe by the fixed latency.

After calibration the client sees a read-valid pulse that coincides with a complete, aligned data word. Error outputs report a configured latency that was too small and a measurement that never completed.

Top module: `rdlat_cal`

## Requirements
- R1: After reset, and until `center_done` is sampled high, the block issues no write, no read and no edge-advance pulse. In that state `cal_done`, `cal_err`, `cal_tmo` and `rd_vld_out` are all low.
- R2: Edge alignment begins with one write cycle in which `cmd_wdata` carries the edge pattern 8'hA5 in every group (bits 8g+7..8g belong to group g). `cmd_rd` is then held high continuously until every group is aligned, and `cmd_wr` and `cmd_rd` are never high together.
- R3: A group whose captured word is the edge pattern with its nibbles swapped (8'h5A) gets a one-cycle pulse on its `edge_adv` bit. A group gets at most one such pulse. A group is counted as aligned once its word equals 8'hA5, and a group that arrives aligned gets no pulse.
- R4: Latency measurement consists of one write cycle carrying 8'h3C in every group, followed by exactly one single-cycle read. A device's latency is the number of clock edges from the edge that samples that read to the edge at which all of the device's groups show 8'h3C. Device d owns groups 2d and 2d+1.
- R5: The fixed latency F equals `cfg_lat` when `cfg_lat_en` is high and `cfg_lat` is at least the largest measured latency. In every other case F equals the largest measured latency.
- R6: When `cfg_lat_en` is high and `cfg_lat` is below the largest measured latency, `cal_err` is high together with `cal_done`, and F is the largest measured latency.
- R7: After `cal_done`, a `rd_cmd_vld` high in the cycle before clock edge k gives exactly one `rd_vld_out` pulse, in the cycle after edge k+F-1.
- R8: Each device's captured data is delayed by F minus that device's latency, so the whole word read by a command appears on `rd_data_out` in the cycle in which `rd_vld_out` is high.
- R9: If alignment or measurement has not completed 64 cycles after its counting starts, `cal_tmo` rises and stays high, and `cal_done` never rises.
- R10: `cal_done` rises only after F has been loaded, and F is then at least every measured latency. It stays high, and from then on the block issues no further write, read or edge-advance pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| center_done | input | 1 | Capture-clock centering finished; starts calibration |
| cfg_lat_en | input | 1 | Use the configured latency when it is large enough |
| cfg_lat | input | 6 | Configured fixed latency in cycles |
| cmd_wr | output | 1 | Calibration write request |
| cmd_rd | output | 1 | Calibration read request |
| cmd_wdata | output | 32 | Write data, one byte per group |
| cap_data | input | 32 | Captured read word, one byte per group |
| edge_adv | output | 4 | Per-group edge-advance pulse |
| rd_cmd_vld | input | 1 | Client read command strobe |
| rd_vld_out | output | 1 | Read-valid, delayed by the fixed latency |
| rd_data_out | output | 32 | Read data after per-device equalisation |
| cal_done | output | 1 | Calibration complete |
| cal_err | output | 1 | Configured latency was below a measured latency |
| cal_tmo | output | 1 | Calibration timed out |

## Verification
Two functions meet in one cycle when a device returns its pattern at count 63. The last group's aligned or found flag then reaches the controller in exactly the cycle in which the timeout comparison against 64 is evaluated. The memory model is given latencies 63 and 64 to provoke this case. It is judged by which of `cal_done` and `cal_tmo` rises, and for latency 63 by the read-valid pulse landing 63 cycles after the strobe.

// File: rtl/rdlat_pkg.sv
package rdlat_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_EWR,
    ST_ERD,
    ST_LWR,
    ST_LRD,
    ST_LWAIT,
    ST_LSET,
    ST_DONE,
    ST_FAIL
  } cal_st_e;

endpackage

// File: rtl/rdlat_edge_chk.sv
module rdlat_edge_chk #(
  parameter int                 NUM_GRP = 4,
  parameter int                 GRP_W   = 8,
  parameter logic [GRP_W-1:0]   PAT     = 8'hA5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     en,
  input  logic [NUM_GRP*GRP_W-1:0] cap,
  output logic [NUM_GRP-1:0]       adv_o,
  output logic [NUM_GRP-1:0]       ok_o
);

  localparam int HALF = GRP_W / 2;
  localparam logic [GRP_W-1:0] SWP = {PAT[HALF-1:0], PAT[GRP_W-1:HALF]};

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic [GRP_W-1:0] word;
    logic ok_q, ok_n, advd_q, advd_n, pul_q, pul_n;

    assign word = cap[g*GRP_W +: GRP_W];

    always_comb begin
      ok_n   = ok_q;
      advd_n = advd_q;
      pul_n  = 1'b0;
      if (clr) begin
        ok_n   = 1'b0;
        advd_n = 1'b0;
      end else if (en && !ok_q) begin
        if (word == PAT) begin
          ok_n = 1'b1;
        end else if ((word == SWP) && !advd_q) begin
          advd_n = 1'b1;
          pul_n  = 1'b1;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ok_q   <= 1'b0;
        advd_q <= 1'b0;
        pul_q  <= 1'b0;
      end else begin
        ok_q   <= ok_n;
        advd_q <= advd_n;
        pul_q  <= pul_n;
      end
    end

    assign adv_o[g] = pul_q;
    assign ok_o[g]  = ok_q;
  end

endmodule

// File: rtl/rdlat_meas.sv
module rdlat_meas #(
  parameter int               NUM_DEV     = 2,
  parameter int               GRP_PER_DEV = 2,
  parameter int               GRP_W       = 8,
  parameter int               LAT_W       = 6,
  parameter logic [GRP_W-1:0] PAT         = 8'h3C
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 clr,
  input  logic                                 en,
  input  logic [LAT_W-1:0]                     cnt,
  input  logic [NUM_DEV*GRP_PER_DEV*GRP_W-1:0] cap,
  output logic [NUM_DEV*LAT_W-1:0]             lat_o,
  output logic [NUM_DEV-1:0]                   found_o
);

  localparam int DEV_W = GRP_PER_DEV * GRP_W;
  localparam logic [DEV_W-1:0] DEV_PAT = {GRP_PER_DEV{PAT}};

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    logic             hit;
    logic             fnd_q, fnd_n;
    logic [LAT_W-1:0] lat_q, lat_n;

    assign hit = (cap[d*DEV_W +: DEV_W] == DEV_PAT);

    always_comb begin
      fnd_n = fnd_q;
      lat_n = lat_q;
      if (clr) begin
        fnd_n = 1'b0;
        lat_n = '0;
      end else if (en && !fnd_q && hit) begin
        fnd_n = 1'b1;
        lat_n = cnt;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        fnd_q <= 1'b0;
        lat_q <= '0;
      end else begin
        fnd_q <= fnd_n;
        lat_q <= lat_n;
      end
    end

    assign lat_o[d*LAT_W +: LAT_W] = lat_q;
    assign found_o[d]              = fnd_q;
  end

endmodule

// File: rtl/rdlat_tap_dly.sv
module rdlat_tap_dly #(
  parameter int W     = 1,
  parameter int DEPTH = 63,
  parameter int SEL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  input  logic [W-1:0]     din,
  output logic [W-1:0]     dout
);

  logic [W-1:0] stg [1:DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 1; i <= DEPTH; i++) stg[i] <= '0;
    end else if (en) begin
      stg[1] <= din;
      for (int i = 2; i <= DEPTH; i++) stg[i] <= stg[i-1];
    end
  end

  always_comb begin
    dout = din;
    for (int i = 1; i <= DEPTH; i++) begin
      if (sel == i[SEL_W-1:0]) dout = stg[i];
    end
  end

endmodule

// File: rtl/rdlat_cal.sv
module rdlat_cal
  import rdlat_pkg::*;
#(
  parameter int               NUM_DEV     = 2,
  parameter int               GRP_PER_DEV = 2,
  parameter int               GRP_W       = 8,
  parameter int               TIMEOUT     = 64,
  parameter logic [GRP_W-1:0] EDGE_PAT    = 8'hA5,
  parameter logic [GRP_W-1:0] LAT_PAT     = 8'h3C
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 center_done,
  input  logic                                 cfg_lat_en,
  input  logic [$clog2(TIMEOUT)-1:0]           cfg_lat,
  output logic                                 cmd_wr,
  output logic                                 cmd_rd,
  output logic [NUM_DEV*GRP_PER_DEV*GRP_W-1:0] cmd_wdata,
  input  logic [NUM_DEV*GRP_PER_DEV*GRP_W-1:0] cap_data,
  output logic [NUM_DEV*GRP_PER_DEV-1:0]       edge_adv,
  input  logic                                 rd_cmd_vld,
  output logic                                 rd_vld_out,
  output logic [NUM_DEV*GRP_PER_DEV*GRP_W-1:0] rd_data_out,
  output logic                                 cal_done,
  output logic                                 cal_err,
  output logic                                 cal_tmo
);

  localparam int NUM_GRP = NUM_DEV * GRP_PER_DEV;
  localparam int DEV_W   = GRP_PER_DEV * GRP_W;
  localparam int BUS_W   = NUM_GRP * GRP_W;
  localparam int LAT_W   = $clog2(TIMEOUT);
  localparam int CNT_W   = $clog2(TIMEOUT + 1);
  localparam int MAX_LAT = TIMEOUT - 1;

  cal_st_e            st_q, st_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic [LAT_W-1:0]   fix_q, fix_n;
  logic               err_q, err_n;
  logic [LAT_W-1:0]   off_q [NUM_DEV];
  logic [LAT_W-1:0]   off_n [NUM_DEV];

  logic [NUM_GRP-1:0]       grp_ok;
  logic [NUM_DEV-1:0]       dev_found;
  logic [NUM_DEV*LAT_W-1:0] lat_w;
  logic                     all_ok, all_found, ld_en;
  logic [LAT_W-1:0]         max_lat, sel_lat;
  logic                     cfg_short;
  logic                     vld_dly;

  // edge alignment per byte group
  rdlat_edge_chk #(
    .NUM_GRP (NUM_GRP),
    .GRP_W   (GRP_W),
    .PAT     (EDGE_PAT)
  ) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (st_q == ST_EWR),
    .en    (st_q == ST_ERD),
    .cap   (cap_data),
    .adv_o (edge_adv),
    .ok_o  (grp_ok)
  );

  // per-device return latency
  rdlat_meas #(
    .NUM_DEV     (NUM_DEV),
    .GRP_PER_DEV (GRP_PER_DEV),
    .GRP_W       (GRP_W),
    .LAT_W       (LAT_W),
    .PAT         (LAT_PAT)
  ) u_meas (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (st_q == ST_LRD),
    .en      (st_q == ST_LWAIT),
    .cnt     (cnt_q[LAT_W-1:0]),
    .cap     (cap_data),
    .lat_o   (lat_w),
    .found_o (dev_found)
  );

  assign all_ok    = &grp_ok;
  assign all_found = &dev_found;
  assign ld_en     = (st_q == ST_LSET);

  // latency selection
  always_comb begin
    max_lat = '0;
    for (int d = 0; d < NUM_DEV; d++) begin
      if (lat_w[d*LAT_W +: LAT_W] > max_lat) max_lat = lat_w[d*LAT_W +: LAT_W];
    end
    cfg_short = cfg_lat_en && (cfg_lat < max_lat);
    sel_lat   = (cfg_lat_en && !cfg_short) ? cfg_lat : max_lat;
  end

  // sequencer next state
  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    unique case (st_q)
      ST_IDLE:  if (center_done) st_n = ST_EWR;
      ST_EWR: begin
        st_n  = ST_ERD;
        cnt_n = '0;
      end
      ST_ERD: begin
        if (all_ok)                        st_n  = ST_LWR;
        else if (cnt_q == CNT_W'(TIMEOUT)) st_n  = ST_FAIL;
        else                               cnt_n = cnt_q + CNT_W'(1);
      end
      ST_LWR:   st_n = ST_LRD;
      ST_LRD: begin
        st_n  = ST_LWAIT;
        cnt_n = CNT_W'(1);
      end
      ST_LWAIT: begin
        if (all_found)                     st_n  = ST_LSET;
        else if (cnt_q == CNT_W'(TIMEOUT)) st_n  = ST_FAIL;
        else                               cnt_n = cnt_q + CNT_W'(1);
      end
      ST_LSET:  st_n = ST_DONE;
      ST_DONE:  st_n = ST_DONE;
      ST_FAIL:  st_n = ST_FAIL;
      default:  st_n = ST_IDLE;
    endcase
  end

  // setting next values
  always_comb begin
    fix_n = fix_q;
    err_n = err_q;
    for (int d = 0; d < NUM_DEV; d++) off_n[d] = off_q[d];
    if (ld_en) begin
      fix_n = sel_lat;
      err_n = cfg_short;
      for (int d = 0; d < NUM_DEV; d++) off_n[d] = sel_lat - lat_w[d*LAT_W +: LAT_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      fix_q <= '0;
      err_q <= 1'b0;
      for (int d = 0; d < NUM_DEV; d++) off_q[d] <= '0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      fix_q <= fix_n;
      err_q <= err_n;
      for (int d = 0; d < NUM_DEV; d++) off_q[d] <= off_n[d];
    end
  end

  // command port
  assign cmd_wr = (st_q == ST_EWR) || (st_q == ST_LWR);
  assign cmd_rd = (st_q == ST_ERD) || (st_q == ST_LRD);

  always_comb begin
    cmd_wdata = '0;
    if (st_q == ST_EWR) cmd_wdata = {NUM_GRP{EDGE_PAT}};
    if (st_q == ST_LWR) cmd_wdata = {NUM_GRP{LAT_PAT}};
  end

  // read-valid delay
  rdlat_tap_dly #(
    .W     (1),
    .DEPTH (MAX_LAT),
    .SEL_W (LAT_W)
  ) u_vld_dly (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (1'b1),
    .sel   (fix_q),
    .din   (rd_cmd_vld),
    .dout  (vld_dly)
  );

  // per-device data equalisation
  for (genvar d = 0; d < NUM_DEV; d++) begin : g_ddly
    rdlat_tap_dly #(
      .W     (DEV_W),
      .DEPTH (MAX_LAT),
      .SEL_W (LAT_W)
    ) u_dly (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (1'b1),
      .sel   (off_q[d]),
      .din   (cap_data[d*DEV_W +: DEV_W]),
      .dout  (rd_data_out[d*DEV_W +: DEV_W])
    );
  end

  assign rd_vld_out = cal_done && vld_dly;
  assign cal_done   = (st_q == ST_DONE);
  assign cal_tmo    = (st_q == ST_FAIL);
  assign cal_err    = err_q;

endmodule

// File: rtl/rdlat_cal_sva.sv
module rdlat_cal_sva #(
  parameter int NUM_DEV = 2,
  parameter int NUM_GRP = 4,
  parameter int LAT_W   = 6
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cmd_wr,
  input logic                     cmd_rd,
  input logic [NUM_GRP-1:0]       edge_adv,
  input logic                     rd_vld_out,
  input logic                     cal_done,
  input logic                     cal_err,
  input logic                     cal_tmo,
  input logic [LAT_W-1:0]         fix_q,
  input logic [NUM_DEV*LAT_W-1:0] lat_w
);

  logic [NUM_GRP-1:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= '0;
    else        seen_q <= seen_q | edge_adv;
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_adv
    a_r3_adv_once: assert property (@(posedge clk) disable iff (!rst_n)
      edge_adv[g] |-> !seen_q[g]);
    a_r3_adv_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      edge_adv[g] |=> !edge_adv[g]);
  end

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_fix
    a_r10_fix_covers: assert property (@(posedge clk) disable iff (!rst_n)
      cal_done |-> (fix_q >= lat_w[d*LAT_W +: LAT_W]));
  end

  a_r2_cmd_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_wr && cmd_rd));

  a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |=> cal_done);

  a_r10_quiet_after: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |-> (!cmd_wr && !cmd_rd && (edge_adv == '0)));

  a_r10_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_done) |-> (fix_q != '0));

  a_r7_vld_gated: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld_out |-> cal_done);

  a_r6_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    cal_err |-> cal_done);

  a_r9_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(cal_done && cal_tmo));

  a_r9_tmo_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cal_tmo |=> cal_tmo);

endmodule

bind rdlat_cal rdlat_cal_sva #(
  .NUM_DEV (NUM_DEV),
  .NUM_GRP (NUM_DEV * GRP_PER_DEV),
  .LAT_W   ($clog2(TIMEOUT))
) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_wr     (cmd_wr),
  .cmd_rd     (cmd_rd),
  .edge_adv   (edge_adv),
  .rd_vld_out (rd_vld_out),
  .cal_done   (cal_done),
  .cal_err    (cal_err),
  .cal_tmo    (cal_tmo),
  .fix_q      (fix_q),
  .lat_w      (lat_w)
);

// File: tb/rdlat_cal_bench.sv
`timescale 1ns/1ps
module rdlat_cal_bench;

  localparam int NUM_DEV = 2;
  localparam int GPD     = 2;
  localparam int GRP_W   = 8;
  localparam int NUM_GRP = NUM_DEV * GPD;
  localparam int BUS_W   = NUM_GRP * GRP_W;
  localparam int HIST    = 70;
  localparam logic [BUS_W-1:0] EDGE_WORD = {NUM_GRP{8'hA5}};
  localparam logic [BUS_W-1:0] LAT_WORD  = {NUM_GRP{8'h3C}};
  localparam logic [BUS_W-1:0] USER_WORD = 32'h9A6B_17E4;

  typedef struct packed {
    logic [6:0] lat0;
    logic [6:0] lat1;
    logic       cfg_en;
    logic [5:0] cfg;
    logic [3:0] mis;
    logic [6:0] exp_f;
    logic       exp_err;
    logic       exp_tmo;
  } scen_t;

  localparam int NSC = 8;
  localparam scen_t TBL [NSC] = '{
    '{7'd3,  7'd5,  1'b0, 6'd0,  4'b0000, 7'd5,  1'b0, 1'b0},
    '{7'd7,  7'd2,  1'b1, 6'd9,  4'b0101, 7'd9,  1'b0, 1'b0},
    '{7'd4,  7'd4,  1'b1, 6'd2,  4'b1111, 7'd4,  1'b1, 1'b0},
    '{7'd1,  7'd1,  1'b0, 6'd12, 4'b1000, 7'd1,  1'b0, 1'b0},
    '{7'd63, 7'd10, 1'b0, 6'd0,  4'b0100, 7'd63, 1'b0, 1'b0},
    '{7'd6,  7'd64, 1'b0, 6'd0,  4'b0000, 7'd0,  1'b0, 1'b1},
    '{7'd5,  7'd5,  1'b1, 6'd5,  4'b0011, 7'd5,  1'b0, 1'b0},
    '{7'd2,  7'd9,  1'b1, 6'd63, 4'b0010, 7'd63, 1'b0, 1'b0}
  };

  logic             clk;
  logic             rst_n;
  logic             center_done;
  logic             cfg_lat_en;
  logic [5:0]       cfg_lat;
  logic             cmd_wr, cmd_rd;
  logic [BUS_W-1:0] cmd_wdata;
  logic [BUS_W-1:0] cap_data;
  logic [NUM_GRP-1:0] edge_adv;
  logic             rd_cmd_vld;
  logic             rd_vld_out;
  logic [BUS_W-1:0] rd_data_out;
  logic             cal_done, cal_err, cal_tmo;

  rdlat_cal u_rdlat_cal (
    .clk         (clk),
    .rst_n       (rst_n),
    .center_done (center_done),
    .cfg_lat_en  (cfg_lat_en),
    .cfg_lat     (cfg_lat),
    .cmd_wr      (cmd_wr),
    .cmd_rd      (cmd_rd),
    .cmd_wdata   (cmd_wdata),
    .cap_data    (cap_data),
    .edge_adv    (edge_adv),
    .rd_cmd_vld  (rd_cmd_vld),
    .rd_vld_out  (rd_vld_out),
    .rd_data_out (rd_data_out),
    .cal_done    (cal_done),
    .cal_err     (cal_err),
    .cal_tmo     (cal_tmo)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // memory model
  int               lat_m [NUM_DEV];
  logic [3:0]       mis_cfg;
  logic             use_user;
  logic [BUS_W-1:0] mem_q;
  logic [BUS_W-1:0] snap [HIST];
  logic             vh   [HIST];
  logic [NUM_GRP-1:0] adv_seen;
  logic [3:0]       adv_cnt [NUM_GRP];
  logic [3:0]       wr_cnt;
  logic [3:0]       rd_after;
  logic [BUS_W-1:0] wd [2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q    <= '0;
      adv_seen <= '0;
      wr_cnt   <= '0;
      rd_after <= '0;
      wd[0]    <= '0;
      wd[1]    <= '0;
      for (int i = 0; i < HIST; i++) begin
        snap[i] <= '0;
        vh[i]   <= 1'b0;
      end
      for (int g = 0; g < NUM_GRP; g++) adv_cnt[g] <= '0;
    end else begin
      vh[0]   <= cmd_rd | rd_cmd_vld;
      snap[0] <= use_user ? USER_WORD : mem_q;
      for (int i = 1; i < HIST; i++) begin
        vh[i]   <= vh[i-1];
        snap[i] <= snap[i-1];
      end
      if (cmd_wr) begin
        mem_q <= cmd_wdata;
        if (wr_cnt < 4'd2) wd[wr_cnt[0]] <= cmd_wdata;
        wr_cnt <= wr_cnt + 4'd1;
      end
      if (cmd_rd && wr_cnt >= 4'd2) rd_after <= rd_after + 4'd1;
      adv_seen <= adv_seen | edge_adv;
      for (int g = 0; g < NUM_GRP; g++) adv_cnt[g] <= adv_cnt[g] + {3'd0, edge_adv[g]};
    end
  end

  always_comb begin
    logic [GRP_W-1:0] w;
    cap_data = '0;
    for (int d = 0; d < NUM_DEV; d++) begin
      for (int k = 0; k < GPD; k++) begin
        w = '0;
        if (lat_m[d] >= 1 && lat_m[d] <= HIST) begin
          if (vh[lat_m[d]-1]) begin
            w = snap[lat_m[d]-1][(d*GPD+k)*GRP_W +: GRP_W];
            if (mis_cfg[d*GPD+k] && !adv_seen[d*GPD+k]) w = {w[3:0], w[7:4]};
          end
        end
        cap_data[(d*GPD+k)*GRP_W +: GRP_W] = w;
      end
    end
  end

  // check bookkeeping
  int n_chk, n_fail;

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic do_reset();
    rst_n       = 1'b0;
    center_done = 1'b0;
    rd_cmd_vld  = 1'b0;
    use_user    = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic run_scen(input int idx);
    scen_t s;
    int first_hit, hits;
    logic [BUS_W-1:0] hit_data;
    s = TBL[idx];
    lat_m[0]   = int'(s.lat0);
    lat_m[1]   = int'(s.lat1);
    mis_cfg    = s.mis;
    cfg_lat_en = s.cfg_en;
    cfg_lat    = s.cfg;
    do_reset();
    center_done = 1'b1;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (cal_done || cal_tmo) break;
    end
    // R9: timeout versus completion
    chk(cal_tmo == s.exp_tmo, "R9 tmo", cal_tmo, s.exp_tmo);
    chk(cal_done == !s.exp_tmo, "R9 done", cal_done, !s.exp_tmo);
    if (!s.exp_tmo) begin
      repeat (5) @(negedge clk);
      chk(cal_err == s.exp_err, "R6 err flag", cal_err, s.exp_err);
      chk(wr_cnt == 4'd2, "R2 write count", wr_cnt, 2);
      chk(wd[0] == EDGE_WORD, "R2 edge pattern", wd[0], EDGE_WORD);
      chk(wd[1] == LAT_WORD, "R4 latency pattern", wd[1], LAT_WORD);
      chk(rd_after == 4'd1, "R4 single read", rd_after, 1);
      for (int g = 0; g < NUM_GRP; g++)
        chk(adv_cnt[g] == {3'd0, s.mis[g]}, "R3 advance count", adv_cnt[g], s.mis[g]);
      // R7/R8: user read after calibration
      use_user = 1'b1;
      repeat (2) @(negedge clk);
      rd_cmd_vld = 1'b1;
      first_hit  = 0;
      hits       = 0;
      hit_data   = '0;
      for (int i = 1; i <= int'(s.exp_f) + 3; i++) begin
        @(negedge clk);
        rd_cmd_vld = 1'b0;
        if (rd_vld_out) begin
          hits++;
          if (first_hit == 0) begin
            first_hit = i;
            hit_data  = rd_data_out;
          end
        end
      end
      chk(first_hit == int'(s.exp_f), "R7 valid delay", first_hit, s.exp_f);
      chk(hits == 1, "R7 single pulse", hits, 1);
      chk(hit_data == USER_WORD, "R8 aligned data", hit_data, USER_WORD);
      chk(rd_after == 4'd1 && cal_done, "R10 quiet and done", rd_after, 1);
    end
  endtask

  initial begin
    n_chk = 0;
    n_fail = 0;
    lat_m[0] = 3;
    lat_m[1] = 3;
    mis_cfg = '0;
    cfg_lat_en = 1'b0;
    cfg_lat = '0;
    do_reset();
    // R1: idle until centering completes
    repeat (10) @(negedge clk);
    chk(!cmd_wr && !cmd_rd && edge_adv == '0, "R1 no commands", {cmd_wr, cmd_rd, edge_adv}, 0);
    chk(!cal_done && !cal_err && !cal_tmo && !rd_vld_out, "R1 flags low",
        {cal_done, cal_err, cal_tmo, rd_vld_out}, 0);
    chk(wr_cnt == 4'd0, "R1 no write", wr_cnt, 0);
    for (int i = 0; i < NSC; i++) run_scen(i);
    // R5: configured value equal to measured maximum keeps it, no error
    cfg_lat_en = 1'b1;
    cfg_lat    = 6'd5;
    lat_m[0]   = 5;
    lat_m[1]   = 1;
    mis_cfg    = 4'b0000;
    do_reset();
    center_done = 1'b1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (cal_done) break;
    end
    chk(cal_done && !cal_err, "R5 equal config", {cal_done, cal_err}, 2);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule